// File: doc/BRIEF.md
# EEPROM Burst Loader

This block sits between a small host register file and an external byte-wide EEPROM. Software can move single bytes in either direction through an address register, a data register and a control register whose request bits clear themselves once the transfer is done. A third request bit starts a burst. In a burst the block walks the EEPROM on its own and copies each configuration record it finds into device memory through a simple write port.

Each burst record is three EEPROM bytes: the low address byte, then the high address byte, then one data byte. The block writes the data byte to a 24-bit memory location. A base register gives the upper 9 bits of that location. The record supplies the lower 15 bits, and the top bit of its 16-bit address is discarded. A record whose 16-bit address is all ones ends the burst.

The block keeps a sticky EEPROM pointer. After reset the pointer is 0. Every byte transferred, whether single or burst, leaves the pointer at the address that follows it. A burst therefore starts at location 0 only if nothing has been transferred since reset, and otherwise continues where the last access stopped. The EEPROM itself is reached through an abstract request/acknowledge byte interface.

Top module: `eeprom_burst_loader`

## Requirements
- R1: Writing the control register (offset 0) with bit 1 set, while idle, reads the EEPROM byte at the address register (offset 1) into the data register (offset 2, bits [7:0], upper bits read 0). Control bit 1 reads 1 from the cycle after the write until the read completes, then reads 0, and the data register is valid from then on.
- R2: Writing control bit 0 while idle writes the data register byte to the EEPROM location in the address register. Control bit 0 reads 1 until the EEPROM acknowledges the write, then clears itself.
- R3: If more than one request bit is set in one control write, the order of priority is read (bit 1), then write (bit 0), then burst (bit 2). Only the winning operation starts, so read and write together produce a read and no EEPROM write.
- R4: Control bit 2 starts a burst and reads 1 until the burst ends. Control bit 3 reads 1 while any operation is active. After reset all registers read 0 and no EEPROM request or memory write is issued.
- R5: A burst started after reset with no earlier transfer reads from EEPROM address 0 onward.
- R6: The EEPROM pointer holds the address after the last byte transferred by a single access or a burst, and the next burst starts there.
- R7: Each burst record is read as low address byte, high address byte, then data byte. The data byte is written once to memory address {base register (offset 3) bits [8:0], high byte bits [6:0], low byte}, with one-cycle mem_we. Bit 7 of the high byte is ignored.
- R8: A record address of 0xFFFF ends the burst. No data byte is read for it and no memory write is made.
- R9: The pointer wraps from the top EEPROM address (2^EE_AW - 1) to 0.
- R10: Host writes to any register while an operation is active are ignored.
- R11: Once an EEPROM request is raised, the request, address, direction and write data stay steady until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 address, 2 data, 3 base |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ee_req | output | 1 | EEPROM byte request, held until ee_ack |
| ee_we | output | 1 | 1 = write byte, 0 = read byte |
| ee_addr | output | 12 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle completion of the current request |
| ee_rdata | input | 8 | Read byte, valid with ee_ack |
| mem_we | output | 1 | Device memory write strobe |
| mem_addr | output | 24 | Device memory byte address |
| mem_wdata | output | 8 | Device memory write data |

## Verification
A corrupted EEPROM pointer shows up on the very next burst. The first ee_addr of that burst is wrong, and so are the memory addresses and data that follow within a few cycles, because the records are fetched from the wrong place. A stuck or lost sequencer state shows in the control register: a request bit or the busy bit fails to clear, or the acknowledge count seen by the EEPROM model differs from the record layout. A base or record byte latched at the wrong time appears on mem_addr in the cycle after the data byte is acknowledged.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_WR, ST_LO, ST_HI, ST_DAT
   } eeb_state_t;

   typedef enum logic [1:0] {
      OP_NONE, OP_RD, OP_WR, OP_BURST
   } eeb_op_t;

   // register indices
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_ADDR = 1;
   localparam int unsigned REG_DATA = 2;
   localparam int unsigned REG_BASE = 3;

   // control bit positions
   localparam int unsigned CB_WR    = 0;
   localparam int unsigned CB_RD    = 1;
   localparam int unsigned CB_BURST = 2;
   localparam int unsigned CB_BUSY  = 3;
endpackage

// File: rtl/eeb_regfile.sv
module eeb_regfile
   import eeb_pkg::*;
#(
   parameter int unsigned EE_AW  = 12,
   parameter int unsigned BASE_W = 9,
   parameter int unsigned DW     = 32,
   parameter int unsigned RAW    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  eeb_state_t        state,
   input  logic              busy,
   input  logic              rd_done,
   input  logic [7:0]        rd_byte,
   output logic [EE_AW-1:0]  addr_q,
   output logic [7:0]        data_q,
   output logic [BASE_W-1:0] base_q,
   output eeb_op_t           start_op
);
   localparam logic [RAW-1:0] IX_CTRL = RAW'(REG_CTRL);
   localparam logic [RAW-1:0] IX_ADDR = RAW'(REG_ADDR);
   localparam logic [RAW-1:0] IX_DATA = RAW'(REG_DATA);
   localparam logic [RAW-1:0] IX_BASE = RAW'(REG_BASE);

   logic wr_ok;
   logic unused_wdata;

   assign wr_ok        = reg_wr && !busy;
   assign unused_wdata = ^reg_wdata;

   // request decode with fixed priority: read, write, burst
   always_comb begin
      start_op = OP_NONE;
      if (wr_ok && reg_addr == IX_CTRL) begin
         if (reg_wdata[CB_RD])         start_op = OP_RD;
         else if (reg_wdata[CB_WR])    start_op = OP_WR;
         else if (reg_wdata[CB_BURST]) start_op = OP_BURST;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         base_q <= '0;
      end else begin
         if (wr_ok && reg_addr == IX_ADDR) addr_q <= reg_wdata[EE_AW-1:0];
         if (wr_ok && reg_addr == IX_BASE) base_q <= reg_wdata[BASE_W-1:0];
         if (wr_ok && reg_addr == IX_DATA) data_q <= reg_wdata[7:0];
         else if (rd_done)                 data_q <= rd_byte;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         IX_CTRL: begin
            reg_rdata[CB_WR]    = (state == ST_WR);
            reg_rdata[CB_RD]    = (state == ST_RD);
            reg_rdata[CB_BURST] = (state == ST_LO) || (state == ST_HI) ||
                                  (state == ST_DAT);
            reg_rdata[CB_BUSY]  = busy;
         end
         IX_ADDR: reg_rdata[EE_AW-1:0]  = addr_q;
         IX_DATA: reg_rdata[7:0]        = data_q;
         IX_BASE: reg_rdata[BASE_W-1:0] = base_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/eeb_engine.sv
module eeb_engine
   import eeb_pkg::*;
#(
   parameter int unsigned EE_AW = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  eeb_op_t          start_op,
   input  logic [EE_AW-1:0] addr_q,
   input  logic [7:0]       data_q,
   input  logic             ee_ack,
   input  logic [7:0]       ee_rdata,
   output eeb_state_t       state,
   output logic             ee_req,
   output logic             ee_we,
   output logic [EE_AW-1:0] ee_addr,
   output logic [7:0]       ee_wdata,
   output logic             rd_done,
   output logic             rec_fire,
   output logic [15:0]      rec_addr
);
   localparam logic [EE_AW-1:0] ONE = EE_AW'(1);

   eeb_state_t       state_q;
   logic [EE_AW-1:0] ptr_q;
   logic [7:0]       lo_q, hi_q;
   logic             single;

   assign state    = state_q;
   assign single   = (state_q == ST_RD) || (state_q == ST_WR);
   assign ee_req   = (state_q != ST_IDLE);
   assign ee_we    = (state_q == ST_WR);
   assign ee_addr  = single ? addr_q : ptr_q;
   assign ee_wdata = data_q;
   assign rd_done  = (state_q == ST_RD) && ee_ack;
   assign rec_fire = (state_q == ST_DAT) && ee_ack;
   assign rec_addr = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               case (start_op)
                  OP_RD:    state_q <= ST_RD;
                  OP_WR:    state_q <= ST_WR;
                  OP_BURST: state_q <= ST_LO;
                  default:  state_q <= ST_IDLE;
               endcase
            end
            ST_RD, ST_WR: begin
               if (ee_ack) begin
                  ptr_q   <= addr_q + ONE;
                  state_q <= ST_IDLE;
               end
            end
            ST_LO: begin
               if (ee_ack) begin
                  lo_q    <= ee_rdata;
                  ptr_q   <= ptr_q + ONE;
                  state_q <= ST_HI;
               end
            end
            ST_HI: begin
               if (ee_ack) begin
                  hi_q  <= ee_rdata;
                  ptr_q <= ptr_q + ONE;
                  if ({ee_rdata, lo_q} == 16'hFFFF) state_q <= ST_IDLE;
                  else                              state_q <= ST_DAT;
               end
            end
            ST_DAT: begin
               if (ee_ack) begin
                  ptr_q   <= ptr_q + ONE;
                  state_q <= ST_LO;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eeb_memport.sv
module eeb_memport #(
   parameter int unsigned BASE_W = 9,
   parameter int unsigned LOW_W  = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rec_fire,
   input  logic [LOW_W-1:0]        rec_low,
   input  logic [7:0]              rec_byte,
   input  logic [BASE_W-1:0]       base_q,
   output logic                    mem_we,
   output logic [BASE_W+LOW_W-1:0] mem_addr,
   output logic [7:0]              mem_wdata
);
   localparam int unsigned MEM_AW = BASE_W + LOW_W;

   logic [MEM_AW-1:0] full_addr;

   // base supplies the upper field, the record the lower field
   genvar gi;
   generate
      for (gi = 0; gi < MEM_AW; gi++) begin : g_abit
         if (gi < LOW_W) begin : g_low
            assign full_addr[gi] = rec_low[gi];
         end else begin : g_base
            assign full_addr[gi] = base_q[gi-LOW_W];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= rec_fire;
         if (rec_fire) begin
            mem_addr  <= full_addr;
            mem_wdata <= rec_byte;
         end
      end
   end
endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
   import eeb_pkg::*;
#(
   parameter int unsigned EE_AW  = 12,
   parameter int unsigned BASE_W = 9,
   parameter int unsigned LOW_W  = 15,
   parameter int unsigned DW     = 32,
   parameter int unsigned RAW    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [RAW-1:0]          reg_addr,
   input  logic [DW-1:0]           reg_wdata,
   output logic [DW-1:0]           reg_rdata,
   output logic                    ee_req,
   output logic                    ee_we,
   output logic [EE_AW-1:0]        ee_addr,
   output logic [7:0]              ee_wdata,
   input  logic                    ee_ack,
   input  logic [7:0]              ee_rdata,
   output logic                    mem_we,
   output logic [BASE_W+LOW_W-1:0] mem_addr,
   output logic [7:0]              mem_wdata
);
   generate
      if (EE_AW < 1 || EE_AW > 16) begin : g_bad_ee_aw
         $error("EE_AW must lie in 1..16");
      end
      if (LOW_W < 9 || LOW_W > 15) begin : g_bad_low_w
         $error("LOW_W must lie in 9..15");
      end
      if (BASE_W < 1 || BASE_W > DW) begin : g_bad_base_w
         $error("BASE_W must lie in 1..DW");
      end
      if (DW < 16 || RAW < 2) begin : g_bad_bus
         $error("DW must be at least 16 and RAW at least 2");
      end
   endgenerate

   eeb_state_t       state;
   eeb_op_t          start_op;
   logic             busy;
   logic             rd_done;
   logic             rec_fire;
   logic [15:0]      rec_addr;
   logic [EE_AW-1:0] addr_q;
   logic [7:0]       data_q;
   logic [BASE_W-1:0] base_q;
   logic             unused_rec;

   assign busy       = (state != ST_IDLE);
   assign unused_rec = ^rec_addr;

   eeb_regfile #(.EE_AW(EE_AW), .BASE_W(BASE_W), .DW(DW), .RAW(RAW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .state     (state),
      .busy      (busy),
      .rd_done   (rd_done),
      .rd_byte   (ee_rdata),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .base_q    (base_q),
      .start_op  (start_op)
   );

   eeb_engine #(.EE_AW(EE_AW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_op (start_op),
      .addr_q   (addr_q),
      .data_q   (data_q),
      .ee_ack   (ee_ack),
      .ee_rdata (ee_rdata),
      .state    (state),
      .ee_req   (ee_req),
      .ee_we    (ee_we),
      .ee_addr  (ee_addr),
      .ee_wdata (ee_wdata),
      .rd_done  (rd_done),
      .rec_fire (rec_fire),
      .rec_addr (rec_addr)
   );

   eeb_memport #(.BASE_W(BASE_W), .LOW_W(LOW_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .rec_fire  (rec_fire),
      .rec_low   (rec_addr[LOW_W-1:0]),
      .rec_byte  (ee_rdata),
      .base_q    (base_q),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/eeb_checker.sv
module eeb_checker #(
   parameter int unsigned EE_AW  = 12,
   parameter int unsigned BASE_W = 9,
   parameter int unsigned LOW_W  = 15,
   parameter int unsigned RAW    = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_wr,
   input logic [RAW-1:0]          reg_addr,
   input logic                    rd_bit,
   input logic                    busy,
   input logic [EE_AW-1:0]        addr_q,
   input logic [BASE_W-1:0]       base_q,
   input logic                    ee_req,
   input logic                    ee_ack,
   input logic                    ee_we,
   input logic [EE_AW-1:0]        ee_addr,
   input logic [7:0]              ee_wdata,
   input logic                    mem_we,
   input logic [BASE_W+LOW_W-1:0] mem_addr
);
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)
                               && $stable(ee_wdata)));

   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> ($stable(addr_q) && $stable(base_q)));

   a_r3_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && reg_addr == '0 && rd_bit) |=> (ee_req && !ee_we));

   a_r7_mem_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(ee_ack));

   a_r7_base_field: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[BASE_W+LOW_W-1:LOW_W] == base_q));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_req);
endmodule

bind eeprom_burst_loader eeb_checker #(
   .EE_AW(EE_AW), .BASE_W(BASE_W), .LOW_W(LOW_W), .RAW(RAW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .rd_bit   (reg_wdata[1]),
   .busy     (busy),
   .addr_q   (addr_q),
   .base_q   (base_q),
   .ee_req   (ee_req),
   .ee_ack   (ee_ack),
   .ee_we    (ee_we),
   .ee_addr  (ee_addr),
   .ee_wdata (ee_wdata),
   .mem_we   (mem_we),
   .mem_addr (mem_addr)
);

// File: tb/eeprom_burst_loader_test.sv
`timescale 1ns/1ps
module eeprom_burst_loader_test;
   localparam int EE_AW = 12;
   localparam int DEPTH = 1 << EE_AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ee_req, ee_we;
   logic [11:0] ee_addr;
   logic [7:0]  ee_wdata;
   logic        ee_ack = 1'b0;
   logic [7:0]  ee_rdata = '0;
   logic        mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;

   eeprom_burst_loader uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
      .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
      .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // EEPROM behavioural model (contents written only by the tasks)
   logic [7:0] ee_mem [DEPTH];
   int ee_lat = 2;
   int lat_cnt = 0;
   int n_acks = 0;
   int n_ee_wr = 0;
   logic [11:0] last_wr_addr = '0;
   logic [7:0]  last_wr_data = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         ee_ack  <= 1'b0;
         lat_cnt <= 0;
      end else if (ee_ack) begin
         ee_ack <= 1'b0;
      end else if (ee_req) begin
         if (lat_cnt >= ee_lat) begin
            ee_ack   <= 1'b1;
            ee_rdata <= ee_mem[ee_addr];
            lat_cnt  <= 0;
            n_acks   <= n_acks + 1;
            if (ee_we) begin
               n_ee_wr      <= n_ee_wr + 1;
               last_wr_addr <= ee_addr;
               last_wr_data <= ee_wdata;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // request stability monitor (R11)
   logic        pend = 1'b0;
   logic [11:0] pend_addr = '0;
   int n_unstable = 0;
   always @(posedge clk) begin
      if (pend && ee_req && ee_addr != pend_addr) n_unstable <= n_unstable + 1;
      pend      <= ee_req && !ee_ack && rst_n;
      pend_addr <= ee_addr;
   end

   // memory write log
   logic [23:0] log_a [16];
   logic [7:0]  log_d [16];
   int log_n = 0;
   always @(posedge clk) begin
      if (mem_we && log_n < 16) begin
         log_a[log_n] <= mem_addr;
         log_d[log_n] <= mem_wdata;
         log_n <= log_n + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] v;
      bit ok = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         rd_reg(2'd0, v);
         if (v[3] == 1'b0) begin ok = 1; break; end
      end
      check({req, " busy clears"}, {31'd0, ok}, 32'd1);
   endtask

   function automatic logic [23:0] maddr(input logic [8:0] b, input logic [7:0] hi,
                                         input logic [7:0] lo);
      return {b, hi[6:0], lo};
   endfunction

   task automatic t_reset;
      logic [31:0] v;
      for (int a = 0; a < 4; a++) begin
         rd_reg(a[1:0], v);
         check("R4 register reset value", v, 32'd0);
      end
      check("R4 no request after reset", {31'd0, ee_req}, 32'd0);
      check("R4 no mem write after reset", {31'd0, mem_we}, 32'd0);
   endtask

   task automatic t_burst_from_reset;
      logic [31:0] v;
      int a0, l0;
      ee_mem[0] = 8'h34; ee_mem[1] = 8'h12; ee_mem[2] = 8'hAB;
      ee_mem[3] = 8'h01; ee_mem[4] = 8'h80; ee_mem[5] = 8'h77;
      ee_mem[6] = 8'hFF; ee_mem[7] = 8'hFF;
      ee_mem[8] = 8'h10; ee_mem[9] = 8'h00; ee_mem[10] = 8'hC3;
      ee_mem[11] = 8'hFF; ee_mem[12] = 8'hFF;
      wr_reg(2'd3, 32'h1A5);
      a0 = n_acks; l0 = log_n;
      wr_reg(2'd0, 32'h4);
      rd_reg(2'd0, v);
      check("R4 burst and busy bits while bursting", v, 32'hC);
      wait_idle("R4");
      rd_reg(2'd0, v);
      check("R4 burst bit self-clears", v, 32'd0);
      check("R8 bytes read in first burst", n_acks - a0, 8);
      check("R7 records written", log_n - l0, 2);
      check("R5 first record address", log_a[l0], maddr(9'h1A5, 8'h12, 8'h34));
      check("R5 first record data", log_d[l0], 8'hAB);
      check("R7 high byte bit 7 ignored", log_a[l0+1], maddr(9'h1A5, 8'h80, 8'h01));
      check("R7 second record data", log_d[l0+1], 8'h77);
   endtask

   task automatic t_burst_continue;
      int a0, l0;
      a0 = n_acks; l0 = log_n;
      wr_reg(2'd0, 32'h4);
      wait_idle("R6");
      check("R6 bytes read in continued burst", n_acks - a0, 5);
      check("R6 continued burst record count", log_n - l0, 1);
      check("R6 continued burst address", log_a[l0], maddr(9'h1A5, 8'h00, 8'h10));
      check("R6 continued burst data", log_d[l0], 8'hC3);
   endtask

   task automatic t_single_write;
      logic [31:0] v;
      int w0;
      ee_lat = 3;
      w0 = n_ee_wr;
      wr_reg(2'd1, 32'h123);
      wr_reg(2'd2, 32'h5A);
      wr_reg(2'd0, 32'h1);
      rd_reg(2'd0, v);
      check("R2 write bit reads 1 while active", v, 32'h9);
      wait_idle("R2");
      rd_reg(2'd0, v);
      check("R2 write bit self-clears", v, 32'd0);
      check("R2 one EEPROM write", n_ee_wr - w0, 1);
      check("R2 written address", {20'd0, last_wr_addr}, 32'h123);
      check("R2 written data", {24'd0, last_wr_data}, 32'h5A);
   endtask

   task automatic t_single_read;
      logic [31:0] v;
      ee_mem[12'h2C] = 8'h3C;
      wr_reg(2'd1, 32'h2C);
      wr_reg(2'd0, 32'h2);
      rd_reg(2'd0, v);
      check("R1 read bit reads 1 while active", v, 32'hA);
      wait_idle("R1");
      rd_reg(2'd0, v);
      check("R1 read bit self-clears", v, 32'd0);
      rd_reg(2'd2, v);
      check("R1 data register holds byte", v, 32'h3C);
   endtask

   task automatic t_read_wins;
      logic [31:0] v;
      int w0;
      ee_mem[12'h30] = 8'h99;
      wr_reg(2'd1, 32'h30);
      wr_reg(2'd2, 32'h11);
      w0 = n_ee_wr;
      wr_reg(2'd0, 32'h3);
      rd_reg(2'd0, v);
      check("R3 only read bit active", v, 32'hA);
      wait_idle("R3");
      rd_reg(2'd2, v);
      check("R3 read result", v, 32'h99);
      check("R3 write dropped", n_ee_wr - w0, 0);
   endtask

   task automatic t_ptr_after_single;
      int l0;
      ee_mem[12'h31] = 8'h05; ee_mem[12'h32] = 8'h02; ee_mem[12'h33] = 8'hE7;
      ee_mem[12'h34] = 8'hFF; ee_mem[12'h35] = 8'hFF;
      wr_reg(2'd3, 32'h003);
      l0 = log_n;
      wr_reg(2'd0, 32'h4);
      wait_idle("R6");
      check("R6 burst after single record count", log_n - l0, 1);
      check("R6 burst after single address", log_a[l0], maddr(9'h003, 8'h02, 8'h05));
      check("R6 burst after single data", log_d[l0], 8'hE7);
   endtask

   task automatic t_busy_ignore;
      logic [31:0] v;
      int w0;
      ee_lat = 24;
      ee_mem[12'h50] = 8'h42;
      w0 = n_ee_wr;
      wr_reg(2'd1, 32'h50);
      wr_reg(2'd0, 32'h2);
      wr_reg(2'd1, 32'h7FF);
      wr_reg(2'd3, 32'h1FF);
      wr_reg(2'd2, 32'hEE);
      wr_reg(2'd0, 32'h1);
      rd_reg(2'd0, v);
      check("R10 still busy during ignored writes", v, 32'hA);
      wait_idle("R10");
      rd_reg(2'd1, v);
      check("R10 address write ignored", v, 32'h50);
      rd_reg(2'd3, v);
      check("R10 base write ignored", v, 32'h003);
      rd_reg(2'd2, v);
      check("R10 data write ignored", v, 32'h42);
      check("R10 control write ignored", n_ee_wr - w0, 0);
      ee_lat = 2;
   endtask

   task automatic t_wrap;
      int l0, a0;
      ee_mem[DEPTH-1] = 8'h00;
      wr_reg(2'd1, 32'hFFF);
      wr_reg(2'd0, 32'h2);
      wait_idle("R9");
      a0 = n_acks; l0 = log_n;
      wr_reg(2'd0, 32'h4);
      wait_idle("R9");
      check("R9 wrapped burst byte count", n_acks - a0, 8);
      check("R9 wrapped burst record count", log_n - l0, 2);
      check("R9 wrapped burst first address", log_a[l0], maddr(9'h003, 8'h12, 8'h34));
      check("R9 wrapped burst first data", log_d[l0], 8'hAB);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ee_mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_burst_from_reset();
      t_burst_continue();
      t_single_write();
      t_single_read();
      t_read_wins();
      t_ptr_after_single();
      t_busy_ignore();
      t_wrap();
      check("R11 request held steady until ack", n_unstable, 0);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R4 actual=hung expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule